// File: doc/BRIEF.md
# Dual Accumulator ALU with Condition Flags

This block is the arithmetic core of a small 8-bit processor datapath. It keeps two byte-wide accumulators, A and B. The two can also be read and loaded together as one 16-bit accumulator D, with A as the upper byte and B as the lower byte. An operation arrives as an opcode and an operand, qualified by a valid strobe. The block can load a byte into A or B, load a halfword into D, add B into A, and add or subtract a byte operand against either accumulator.

Next to the accumulators sits an 8-bit condition code register. Its five status flags (half-carry, negative, zero, overflow, carry/borrow) are refreshed by operations. Each opcode carries its own update mask, so an operation writes only the flags it is defined to touch. The register also holds two interrupt-mask bits and a stop-control bit. The block keeps these three bits and changes them only through an explicit whole-register write operation. Fetch, decoding of instruction streams, memory and interrupt handling belong to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: After reset, A and B read 0 and the flag register reads 0xD0. The flag bit order from bit 7 down to bit 0 is stop, x-mask, half-carry, i-mask, negative, zero, overflow, carry. So the stop, x-mask and i-mask bits are 1 and all status flags are 0.
- R2: Output `d_q` always equals {A, B}. Load-D (op 3) writes operand[15:8] into A and operand[7:0] into B.
- R3: Load-A (op 1) and Load-B (op 2) copy operand[7:0] into the named accumulator and leave the other one unchanged. They set N to bit 7 of the loaded byte, set Z when that byte is zero and clear V. They leave H and C unchanged.
- R4: Load-D sets N from operand bit 15 and sets Z only when all 16 operand bits are zero. It clears V and leaves H and C unchanged.
- R5: Add-B-to-A (op 4) writes (A+B) mod 256 into A and leaves B unchanged.
- R6: Add-to-A (op 5) and add-to-B (op 7) write (acc + operand[7:0]) mod 256 into the named accumulator. They update H, N, Z, V and C, where C is the carry out of bit 7.
- R7: Subtract-from-A (op 6) and subtract-from-B (op 8) write (acc − operand[7:0]) mod 256. C is set exactly when the operand is unsigned-greater than the accumulator (a borrow). N, Z and V are updated and H is left unchanged.
- R8: On additions, H is set exactly when the low nibbles of the two operands sum to more than 15.
- R9: V is set exactly when the signed (two's-complement) result of the addition or subtraction lies outside −128..127.
- R10: Flag-write (op 9) copies operand[7:0] into the whole flag register. No other operation changes the stop, x-mask or i-mask bits.
- R11: With op_valid low, or with an opcode of 0 or 10..15, A, B and the flag register keep their values.
- R12: One operation is accepted on every clock edge where op_valid is high. Its results and flags are visible after that edge, so back-to-back operations chain without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| op_valid | input | 1 | Operation strobe; one operation per cycle while high |
| op_code | input | 4 | Operation select (codes listed in the requirements) |
| operand | input | 16 | Operand; low byte for byte operations, all 16 bits for Load-D |
| a_q | output | 8 | Accumulator A |
| b_q | output | 8 | Accumulator B |
| d_q | output | 16 | Combined accumulator {A, B} |
| ccr_q | output | 8 | Condition code register |

## Verification
The bench sweeps operand pairs across each arithmetic operation, with every boundary byte (0x00, 0x0F, 0x10, 0x7F, 0x80, 0xFF and neighbours) paired against every other. A design that derived half-carry from the wrong bit, or took the overflow test without inverting the subtrahend sign, would disagree on those pairs. The same holds for one that reported carry instead of borrow on subtraction. Load-D of 0x0100 catches a zero flag computed over only one byte. Running the sweeps with the flag register preset to all ones catches a mask that lets an operation clear the control bits or clobber H and C. Idle cycles and undefined opcodes are run with loaded operands, and the bench confirms that nothing moves.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_LOAD_A   = 4'd1,
    OP_LOAD_B   = 4'd2,
    OP_LOAD_D   = 4'd3,
    OP_SUM_BA   = 4'd4,
    OP_ADD_A    = 4'd5,
    OP_SUB_A    = 4'd6,
    OP_ADD_B    = 4'd7,
    OP_SUB_B    = 4'd8,
    OP_WRITE_CC = 4'd9
  } op_e;

  // flag register bit positions
  localparam int CC_S = 7;
  localparam int CC_X = 6;
  localparam int CC_H = 5;
  localparam int CC_I = 4;
  localparam int CC_N = 3;
  localparam int CC_Z = 2;
  localparam int CC_V = 1;
  localparam int CC_C = 0;

  localparam int          CC_W     = 8;
  localparam logic [7:0]  CC_RESET = 8'hD0;

  localparam logic [7:0] MASK_NONE = 8'h00;
  localparam logic [7:0] MASK_LOAD = (8'h1 << CC_N) | (8'h1 << CC_Z) | (8'h1 << CC_V);
  localparam logic [7:0] MASK_SUB  = MASK_LOAD | (8'h1 << CC_C);
  localparam logic [7:0] MASK_ADD  = MASK_SUB | (8'h1 << CC_H);

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_A    = 2'd1,
    DST_B    = 2'd2,
    DST_D    = 2'd3
  } dst_e;

  typedef struct packed {
    dst_e       dst;
    logic       use_adder;
    logic       sub;
    logic       x_is_b;
    logic       y_is_b;
    logic       wide;
    logic       cc_write;
    logic [7:0] mask;
  } ctrl_t;

endpackage

// File: rtl/acc_alu_rst_sync.sv
module acc_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [3:0] op_code,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl           = '0;
    ctrl.dst       = DST_NONE;
    ctrl.mask      = MASK_NONE;
    case (op_code)
      OP_LOAD_A: begin ctrl.dst = DST_A; ctrl.mask = MASK_LOAD; end
      OP_LOAD_B: begin ctrl.dst = DST_B; ctrl.mask = MASK_LOAD; end
      OP_LOAD_D: begin ctrl.dst = DST_D; ctrl.mask = MASK_LOAD; ctrl.wide = 1'b1; end
      OP_SUM_BA: begin
        ctrl.dst = DST_A; ctrl.use_adder = 1'b1; ctrl.y_is_b = 1'b1; ctrl.mask = MASK_ADD;
      end
      OP_ADD_A: begin ctrl.dst = DST_A; ctrl.use_adder = 1'b1; ctrl.mask = MASK_ADD; end
      OP_SUB_A: begin
        ctrl.dst = DST_A; ctrl.use_adder = 1'b1; ctrl.sub = 1'b1; ctrl.mask = MASK_SUB;
      end
      OP_ADD_B: begin
        ctrl.dst = DST_B; ctrl.use_adder = 1'b1; ctrl.x_is_b = 1'b1; ctrl.mask = MASK_ADD;
      end
      OP_SUB_B: begin
        ctrl.dst = DST_B; ctrl.use_adder = 1'b1; ctrl.x_is_b = 1'b1; ctrl.sub = 1'b1;
        ctrl.mask = MASK_SUB;
      end
      OP_WRITE_CC: ctrl.cc_write = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);
  localparam int HB = W / 2;

  logic [W-1:0] y_eff;
  logic [W:0]   full;

  always_comb begin
    y_eff = sub ? ~y : y;
    full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, sub};
    res   = full[W-1:0];
    c_out = sub ? ~full[W] : full[W];
    h_out = full[HB] ^ x[HB] ^ y_eff[HB];
    v_out = (x[W-1] == y_eff[W-1]) && (res[W-1] != x[W-1]);
  end
endmodule

// File: rtl/acc_alu_cc_merge.sv
module acc_alu_cc_merge #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] cc_old,
  input  logic [CW-1:0] cc_new,
  input  logic [CW-1:0] mask,
  output logic [CW-1:0] cc_out
);
  for (genvar g = 0; g < CW; g++) begin : g_bit
    assign cc_out[g] = mask[g] ? cc_new[g] : cc_old[g];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [3:0]     op_code,
  input  logic [2*W-1:0] operand,
  output logic [W-1:0]   a_q,
  output logic [W-1:0]   b_q,
  output logic [2*W-1:0] d_q,
  output logic [CC_W-1:0] ccr_q
);
  localparam int DW = 2 * W;

  logic            rst_sync_n;
  ctrl_t           ctrl;
  logic [W-1:0]    add_x, add_y, add_res, byte_res;
  logic            add_c, add_h, add_v;
  logic [CC_W-1:0] status, merged;
  logic [W-1:0]    a_nxt, b_nxt;
  logic [CC_W-1:0] ccr_nxt;

  acc_alu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  acc_alu_decode u_decode (.op_code(op_code), .ctrl(ctrl));

  assign add_x = ctrl.x_is_b ? b_q : a_q;
  assign add_y = ctrl.y_is_b ? b_q : operand[W-1:0];

  acc_alu_addsub #(.W(W)) u_addsub (
    .x(add_x), .y(add_y), .sub(ctrl.sub),
    .res(add_res), .c_out(add_c), .h_out(add_h), .v_out(add_v)
  );

  always_comb begin
    byte_res     = ctrl.use_adder ? add_res : operand[W-1:0];
    status       = '0;
    status[CC_H] = add_h;
    status[CC_C] = add_c;
    status[CC_V] = ctrl.use_adder & add_v;
    status[CC_N] = ctrl.wide ? operand[DW-1] : byte_res[W-1];
    status[CC_Z] = ctrl.wide ? (operand == '0) : (byte_res == '0);
  end

  acc_alu_cc_merge #(.CW(CC_W)) u_cc_merge (
    .cc_old(ccr_q), .cc_new(status), .mask(ctrl.mask), .cc_out(merged)
  );

  always_comb begin
    a_nxt   = a_q;
    b_nxt   = b_q;
    ccr_nxt = ccr_q;
    case (ctrl.dst)
      DST_A:   a_nxt = byte_res;
      DST_B:   b_nxt = byte_res;
      DST_D:   {a_nxt, b_nxt} = operand;
      default: ;
    endcase
    ccr_nxt = ctrl.cc_write ? operand[CC_W-1:0] : merged;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      a_q   <= '0;
      b_q   <= '0;
      ccr_q <= CC_RESET;
    end else if (op_valid) begin
      a_q   <= a_nxt;
      b_q   <= b_nxt;
      ccr_q <= ccr_nxt;
    end
  end

  assign d_q = {a_q, b_q};
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [3:0]     op_code,
  input logic [2*W-1:0] operand,
  input logic [W-1:0]   a_q,
  input logic [W-1:0]   b_q,
  input logic [2*W-1:0] d_q,
  input logic [7:0]     ccr_q
);
  logic is_load;
  assign is_load = op_valid && (op_code == OP_LOAD_A || op_code == OP_LOAD_B || op_code == OP_LOAD_D);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(a_q) && $stable(b_q) && $stable(ccr_q)); // R11

  AST_CTRL_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_code == OP_WRITE_CC) |=>
      $stable(ccr_q[CC_S]) && $stable(ccr_q[CC_X]) && $stable(ccr_q[CC_I])); // R10

  AST_SUM_B_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_SUM_BA |=> $stable(b_q)); // R5

  AST_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_LOAD_A |=> a_q == $past(operand[W-1:0]) && $stable(b_q)); // R3

  AST_LOAD_D: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_LOAD_D |=> d_q == $past(operand)); // R2

  AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> !ccr_q[CC_V] && $stable(ccr_q[CC_H]) && $stable(ccr_q[CC_C])); // R3

  AST_SUB_H_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_SUB_A || op_code == OP_SUB_B) |=> $stable(ccr_q[CC_H])); // R7

  AST_ADD_A_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_ADD_A || op_code == OP_SUB_A || op_code == OP_SUM_BA)
      |=> ccr_q[CC_Z] == (a_q == '0)); // R6

  AST_CC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_WRITE_CC |=> ccr_q == $past(operand[7:0])); // R10
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .op_valid(op_valid), .op_code(op_code),
  .operand(operand), .a_q(a_q), .b_q(b_q), .d_q(d_q), .ccr_q(ccr_q)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [15:0] operand;
  logic [7:0]  a_q, b_q, ccr_q;
  logic [15:0] d_q;

  int checks = 0;
  int fails  = 0;
  logic [7:0] ea, eb, ecc;
  logic [7:0] cv [9];

  acc_alu #(.W(8)) u_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .a_q(a_q), .b_q(b_q), .d_q(d_q), .ccr_q(ccr_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check_state(input string tag);
    checks++;
    if (a_q !== ea || b_q !== eb || d_q !== {ea, eb} || ccr_q !== ecc) begin
      fails++;
      $display("FAIL %s: got A=%h B=%h D=%h CC=%h exp A=%h B=%h D=%h CC=%h",
               tag, a_q, b_q, d_q, ccr_q, ea, eb, {ea, eb}, ecc);
    end
  endtask

  task automatic set_nz(input logic [7:0] r8);
    ecc[3] = r8[7];
    ecc[2] = (r8 == 8'h00);
  endtask

  task automatic arith(input int x, input int y, input bit sub, output logic [7:0] r8);
    int r, sx, sy, sr;
    r  = sub ? x - y : x + y;
    r8 = 8'(r & 255);
    sx = (x > 127) ? x - 256 : x;
    sy = (y > 127) ? y - 256 : y;
    sr = sub ? sx - sy : sx + sy;
    if (!sub) ecc[5] = ((x & 15) + (y & 15)) > 15;
    ecc[0] = sub ? (x < y) : (r > 255);
    ecc[1] = (sr > 127) || (sr < -128);
    set_nz(r8);
  endtask

  task automatic model(input logic [3:0] op, input logic [15:0] v);
    logic [7:0] r8;
    case (op)
      4'd1: begin ea = v[7:0]; set_nz(ea); ecc[1] = 1'b0; end
      4'd2: begin eb = v[7:0]; set_nz(eb); ecc[1] = 1'b0; end
      4'd3: begin
        ea = v[15:8]; eb = v[7:0];
        ecc[3] = v[15]; ecc[2] = (v == 16'h0000); ecc[1] = 1'b0;
      end
      4'd4: begin arith(int'(ea), int'(eb), 1'b0, r8); ea = r8; end
      4'd5: begin arith(int'(ea), int'(v[7:0]), 1'b0, r8); ea = r8; end
      4'd6: begin arith(int'(ea), int'(v[7:0]), 1'b1, r8); ea = r8; end
      4'd7: begin arith(int'(eb), int'(v[7:0]), 1'b0, r8); eb = r8; end
      4'd8: begin arith(int'(eb), int'(v[7:0]), 1'b1, r8); eb = r8; end
      4'd9: ecc = v[7:0];
      default: ;
    endcase
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic run_op(input logic [3:0] op, input logic [15:0] v, input string tag);
    op_valid = 1'b1;
    op_code  = op;
    operand  = v;
    @(posedge clk);
    model(op, v);
    @(negedge clk);
    op_valid = 1'b0;
    check_state(tag);
  endtask

  task automatic sweep_pair(input logic [7:0] x, input logic [7:0] y);
    run_op(4'd3, {x, y}, "R2 setup");
    run_op(4'd4, 16'h0, "R5 R8 R9 sum B into A");
    run_op(4'd3, {x, ~x}, "R2 setup");
    run_op(4'd5, {8'h00, y}, "R6 R8 R9 add A");
    run_op(4'd3, {x, ~x}, "R2 setup");
    run_op(4'd6, {8'h00, y}, "R7 R9 sub A");
    run_op(4'd3, {~x, x}, "R2 setup");
    run_op(4'd7, {8'h00, y}, "R6 R8 R9 add B");
    run_op(4'd3, {~x, x}, "R2 setup");
    run_op(4'd8, {8'h00, y}, "R7 R9 sub B");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
    $finish;
  end

  initial begin
    cv = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF};
    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; operand = 16'h0;
    ea = 8'h00; eb = 8'h00; ecc = 8'hD0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 reset");

    // R4 wide load flags
    run_op(4'd3, 16'h8000, "R4 load D negative");
    run_op(4'd3, 16'h0000, "R4 load D zero");
    run_op(4'd3, 16'h0100, "R4 load D zero over 16 bits");
    run_op(4'd3, 16'h00FF, "R4 R2 load D low only");
    // R3 byte loads
    run_op(4'd1, 16'hAB80, "R3 load A");
    run_op(4'd2, 16'h1200, "R3 load B");
    run_op(4'd3, 16'h7FFF, "R2 load D");
    run_op(4'd4, 16'h0, "R5 R8 R9 sum 7F+FF");
    // R10 flag writes
    run_op(4'd9, 16'h0000, "R10 write all zero");
    run_op(4'd5, 16'h0001, "R10 add keeps control bits");
    run_op(4'd9, 16'h00FF, "R10 write all ones");
    run_op(4'd1, 16'h0000, "R10 R3 load keeps control and H C");

    // R12 back-to-back chain
    run_op(4'd1, 16'h0033, "R12 chain load A");
    run_op(4'd2, 16'h0044, "R12 chain load B");
    run_op(4'd4, 16'h0000, "R12 chain sum");
    run_op(4'd6, 16'h0077, "R12 chain sub");

    // R11 idle and undefined codes
    op_valid = 1'b0; op_code = 4'd1; operand = 16'h5A5A;
    repeat (3) @(negedge clk);
    check_state("R11 valid low");
    op_code = 4'd9; operand = 16'h0000;
    @(negedge clk);
    check_state("R11 valid low flag write");
    for (int k = 10; k < 16; k++) run_op(4'(k), 16'hFFFF, "R11 undefined code");
    run_op(4'd0, 16'h1234, "R11 nop");

    // corner pairs with control bits all ones
    run_op(4'd9, 16'h00FF, "R10 preset");
    foreach (cv[i]) foreach (cv[j]) sweep_pair(cv[i], cv[j]);
    run_op(4'd9, 16'h0000, "R10 clear");
    for (int x = 0; x < 256; x += 3)
      for (int y = 0; y < 256; y += 3)
        sweep_pair(8'(x), 8'(y));

    summary();
    $finish;
  end
endmodule